// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a small memory-mapped window of four 32-bit registers through which it can reach a much larger internal register space. The host loads an internal address and, for a store, a data word. It then sets a read or a write request bit in the command register. The bridge runs exactly one transfer on an internal request/ready register bus, raises an acknowledge flag in the command register, and holds that state until the host writes the command back to zero.

The host side is a single-cycle register port: a write takes effect on the clock edge where `h_we` is high, and reads are combinational from `h_off`. The internal side is a bus master. It holds its request, address, direction and write data steady until the target accepts with `ib_ready`, which may come after any number of stall cycles. A clear is always honoured. If the host clears while a transfer is still outstanding, the command register reads zero at once and the bus request is completed quietly in the background, with no acknowledge and no update of the read data.

Top module: `rb_bridge`

## Requirements
- R1: After reset all four window registers read zero and `ib_req` is low.
- R2: Window byte offsets: 0x0 command, 0x4 address, 0x8 read data, 0xC write data, selected by `h_off[3:2]`. An access with `h_off[1:0]` not zero is misaligned: a write is ignored and a read returns zero.
- R3: The address register holds a word address (stride 4). Bits [1:0] are dropped on write and read back as zero, and `ib_addr` carries the same value. The write data register reads back as written.
- R4: A command write of 0b10 in bits [1:0] while idle starts a store. From the next cycle `ib_req` is high with `ib_we`=1, `ib_addr` and `ib_wdata` taken from the window, and the request holds steady until `ib_ready`.
- R5: A command write of 0b01 while idle starts a load with `ib_we`=0. The word on `ib_rdata` in the accepting cycle is captured and reads at offset 0x8 once acknowledge is set.
- R6: Command readback: bit 0 = load pending, bit 1 = store pending, bit 2 = acknowledge, all other bits zero. Acknowledge rises in the cycle after the cycle in which `ib_req` and `ib_ready` are both high. With S stall cycles, the flag is first visible S+1 cycles after the request appears.
- R7: Writing a command with bits [1:0] = 00 while acknowledge is set returns the bridge to idle, and the command register reads exactly zero from the next cycle with `ib_req` low.
- R8: A clear written while a transfer is outstanding makes the command register read zero at once. `ib_req` stays high until `ib_ready`, then drops; acknowledge never rises and the read data register keeps its old value.
- R9: A command with both bits 0 and 1 set is ignored: no request is issued, no acknowledge is raised, and the command register stays zero.
- R10: While the bridge is not idle, writes to the address and write data registers, and non-zero command writes, are ignored.
- R11: The read data register cannot be written by the host, and a store leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_we | input | 1 | Host write strobe, one cycle per write |
| h_off | input | 4 | Host byte offset within the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_off`, combinational |
| ib_req | output | 1 | Internal bus request, held until accepted |
| ib_we | output | 1 | Internal bus direction, 1 = store |
| ib_addr | output | 32 | Internal bus word address |
| ib_wdata | output | 32 | Internal bus store data |
| ib_ready | input | 1 | Internal bus accept / completion |
| ib_rdata | input | 32 | Internal bus load data, valid with `ib_ready` |

## Verification
The assertions watch, on every cycle, the properties of the internal bus handshake. A stalled request keeps its address, data and direction. Acknowledge rises only in the cycle after an accepted transfer and always does so after a normal completion. No request is outstanding while acknowledge is set, an aborted transfer never produces an acknowledge, and a command with both bits set leaves the bridge idle. The bench scenarios must show the values themselves. These are the word that lands in the target and the word captured for a load, the exact number of cycles from request to acknowledge for a given stall count, the readback of every window register, and the fact that ignored writes left the address, write data and read data registers untouched. A scoreboard compares every bus transfer against the expected one.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DONE  = 2'd2,
    ST_DRAIN = 2'd3
  } rb_state_e;

  typedef enum logic [1:0] {
    RQ_NONE = 2'd0,
    RQ_RD   = 2'd1,
    RQ_WR   = 2'd2,
    RQ_BOTH = 2'd3
  } rb_req_e;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_RDAT = 2'd2,
    SEL_WDAT = 2'd3
  } rb_sel_e;

  localparam int CMD_RD_BIT  = 0;
  localparam int CMD_WR_BIT  = 1;
  localparam int CMD_ACK_BIT = 2;
  localparam int CMD_VIEW_W  = 3;

  // Classify the two request bits of a command write.
  function automatic rb_req_e rb_decode(input logic [1:0] bits);
    case (bits)
      2'b00:   return RQ_NONE;
      2'b01:   return RQ_RD;
      2'b10:   return RQ_WR;
      default: return RQ_BOTH;
    endcase
  endfunction

  // Command register as the host sees it, derived from the sequencer state.
  function automatic logic [CMD_VIEW_W-1:0] rb_cmd_view(input rb_state_e st,
                                                       input logic op_we);
    logic [CMD_VIEW_W-1:0] v;
    v = '0;
    if (st == ST_BUSY || st == ST_DONE) begin
      v[CMD_WR_BIT] = op_we;
      v[CMD_RD_BIT] = !op_we;
    end
    if (st == ST_DONE) v[CMD_ACK_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/rb_window.sv
module rb_window
  import rb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  rb_sel_e       sel,
  input  logic [DW-1:0] wdata,
  input  logic          idle,
  input  logic          rd_load,
  input  logic [DW-1:0] ib_rdata,
  output logic [AW-1:0] addr_word,
  output logic [DW-1:0] wdat_q,
  output logic [DW-1:0] rdat_q
);
  localparam int WORD_LSB = $clog2(DW / 8);

  logic [AW-1:WORD_LSB] addr_q;
  logic                 ld_addr;
  logic                 ld_wdat;

  // Operand registers are frozen whenever a command is not idle.
  assign ld_addr = wr_ok && idle && (sel == SEL_ADDR);
  assign ld_wdat = wr_ok && idle && (sel == SEL_WDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (ld_addr) addr_q <= wdata[AW-1:WORD_LSB];
      if (ld_wdat) wdat_q <= wdata;
      if (rd_load) rdat_q <= ib_rdata;
    end
  end

  assign addr_word = {addr_q, {WORD_LSB{1'b0}}};

endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [1:0]            cmd_bits,
  input  logic                  ib_ready,
  output logic                  ib_req,
  output logic                  ib_we,
  output logic                  idle,
  output logic                  ack,
  output logic [CMD_VIEW_W-1:0] cmd_view,
  output logic                  ev_issue,
  output logic                  ev_complete,
  output logic                  ev_abort,
  output logic                  rd_load
);
  rb_state_e st_q, st_d;
  logic      op_we_q;
  rb_req_e   kind;
  logic      ev_clear;
  logic      hs;

  assign kind        = rb_decode(cmd_bits);
  assign ev_clear    = cmd_wr && (kind == RQ_NONE);
  assign hs          = ib_req && ib_ready;
  assign ev_issue    = (st_q == ST_IDLE) && cmd_wr && (kind == RQ_RD || kind == RQ_WR);
  assign ev_complete = (st_q == ST_BUSY) && hs && !ev_clear;
  assign ev_abort    = (st_q == ST_BUSY) && ev_clear;
  assign rd_load     = ev_complete && !op_we_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (ev_issue) st_d = ST_BUSY;
      ST_BUSY: begin
        if (ev_abort)         st_d = hs ? ST_IDLE : ST_DRAIN;
        else if (ev_complete) st_d = ST_DONE;
      end
      ST_DONE:  if (ev_clear) st_d = ST_IDLE;
      ST_DRAIN: if (hs)       st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_we_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_issue) op_we_q <= (kind == RQ_WR);
    end
  end

  assign ib_req   = (st_q == ST_BUSY) || (st_q == ST_DRAIN);
  assign ib_we    = op_we_q;
  assign idle     = (st_q == ST_IDLE);
  assign ack      = (st_q == ST_DONE);
  assign cmd_view = rb_cmd_view(st_q, op_we_q);

endmodule

// File: rtl/rb_bridge.sv
module rb_bridge
  import rb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int WORD_LSB = $clog2(DW / 8),
  localparam int WIN_AW = WORD_LSB + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [WIN_AW-1:0] h_off,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              ib_req,
  output logic              ib_we,
  output logic [AW-1:0]     ib_addr,
  output logic [DW-1:0]     ib_wdata,
  input  logic              ib_ready,
  input  logic [DW-1:0]     ib_rdata
);
  rb_sel_e               sel;
  logic                  aligned;
  logic                  wr_ok;
  logic                  cmd_wr;
  logic                  idle;
  logic                  ack;
  logic                  rd_load;
  logic                  ev_issue;
  logic                  ev_complete;
  logic                  ev_abort;
  logic [CMD_VIEW_W-1:0] cmd_view;
  logic [DW-1:0]         rdat_q;

  assign aligned = (h_off[WORD_LSB-1:0] == '0);
  assign sel     = rb_sel_e'(h_off[WIN_AW-1:WORD_LSB]);
  assign wr_ok   = h_we && aligned;
  assign cmd_wr  = wr_ok && (sel == SEL_CMD);

  rb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_bits   (h_wdata[1:0]),
    .ib_ready   (ib_ready),
    .ib_req     (ib_req),
    .ib_we      (ib_we),
    .idle       (idle),
    .ack        (ack),
    .cmd_view   (cmd_view),
    .ev_issue   (ev_issue),
    .ev_complete(ev_complete),
    .ev_abort   (ev_abort),
    .rd_load    (rd_load)
  );

  rb_window #(.AW(AW), .DW(DW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .sel      (sel),
    .wdata    (h_wdata),
    .idle     (idle),
    .rd_load  (rd_load),
    .ib_rdata (ib_rdata),
    .addr_word(ib_addr),
    .wdat_q   (ib_wdata),
    .rdat_q   (rdat_q)
  );

  always_comb begin
    h_rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_CMD:  h_rdata = {{(DW-CMD_VIEW_W){1'b0}}, cmd_view};
        SEL_ADDR: h_rdata = DW'(ib_addr);
        SEL_RDAT: h_rdata = rdat_q;
        SEL_WDAT: h_rdata = ib_wdata;
        default:  h_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rb_bridge_chk.sv
module rb_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WIN_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_we,
  input logic [WIN_AW-1:0] h_off,
  input logic [1:0]        cmd_bits,
  input logic              ib_req,
  input logic              ib_ready,
  input logic              ib_we,
  input logic [AW-1:0]     ib_addr,
  input logic [DW-1:0]     ib_wdata,
  input logic              ack,
  input logic              idle,
  input logic              ev_issue,
  input logic              ev_complete,
  input logic              ev_abort
);
  // R4: a request that is not accepted stays up with unchanged operands.
  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ready |=> ib_req);
  // R10: operands cannot move under a stalled request.
  p_operands_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ready |=> $stable(ib_addr) && $stable(ib_wdata) && $stable(ib_we));
  // R4: an accepted command puts a request on the bus next cycle.
  p_issue_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> ib_req);
  // R6: normal completion raises acknowledge one cycle later.
  p_ack_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> ack);
  // R6: acknowledge only rises after an accepted transfer.
  p_ack_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(ib_req && ib_ready));
  // R7: nothing is outstanding while acknowledge is shown.
  p_quiet_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ib_req);
  // R8: an aborted transfer never produces acknowledge.
  p_abort_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !ack);
  // R9: a command with both bits set leaves the bridge idle.
  p_both_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle && h_we && (h_off == '0) && (cmd_bits == 2'b11) |=> idle && !ib_req);
endmodule

bind rb_bridge rb_bridge_chk #(.AW(AW), .DW(DW), .WIN_AW(WIN_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h_we       (h_we),
  .h_off      (h_off),
  .cmd_bits   (h_wdata[1:0]),
  .ib_req     (ib_req),
  .ib_ready   (ib_ready),
  .ib_we      (ib_we),
  .ib_addr    (ib_addr),
  .ib_wdata   (ib_wdata),
  .ack        (ack),
  .idle       (idle),
  .ev_issue   (ev_issue),
  .ev_complete(ev_complete),
  .ev_abort   (ev_abort)
);

// File: tb/sim_rb_bridge.sv
module sim_rb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_we = 1'b0;
  logic [3:0]  h_off = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        ib_req, ib_we;
  logic [31:0] ib_addr, ib_wdata;
  logic        ib_ready = 1'b0;
  logic [31:0] ib_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int stall = 0;

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } txn_t;
  txn_t exp_q[$];
  logic [31:0] mem [0:15];

  always #10 clk = ~clk;

  rb_bridge u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_off = off; h_wdata = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic hr(input logic [3:0] off, output logic [31:0] v);
    h_off = off;
    #1 v = h_rdata;
  endtask

  task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d);
    txn_t t;
    t.we = we; t.addr = a; t.data = d;
    exp_q.push_back(t);
  endtask

  task automatic wait_ack(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      hr(4'h0, v);
      if (v[2]) break;
      @(negedge clk);
      n++;
    end
  endtask

  // Internal target model plus scoreboard monitor.
  initial begin
    int cnt;
    int idx;
    txn_t t;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (ib_ready) begin
        ib_ready = 1'b0;
        cnt = 0;
      end else if (ib_req) begin
        if (cnt == stall) begin
          idx = int'(ib_addr[5:2]);
          ib_ready = 1'b1;
          if (ib_we) mem[idx] = ib_wdata;
          else       ib_rdata = mem[idx];
          if (exp_q.size() == 0) begin
            chk("R4 unexpected bus transfer", 32'h1, 32'h0);
          end else begin
            t = exp_q.pop_front();
            chk(ib_we ? "R4 bus dir" : "R5 bus dir", {31'b0, ib_we}, {31'b0, t.we});
            chk("R3 bus addr", ib_addr, t.addr);
            if (t.we) chk("R4 bus wdata", ib_wdata, t.data);
          end
        end else begin
          cnt++;
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + 32'(i) * 32'h111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      hr(4'(i * 4), v);
      chk("R1 reset readback", v, 32'h0);
    end
    chk("R1 no request", {31'b0, ib_req}, 32'h0);

    // R4/R6/R11: store with 2 stall cycles
    hw(4'hC, 32'hDEAD_BEEF);
    hw(4'h4, 32'h0000_0024);
    hr(4'h4, v); chk("R2 addr readback", v, 32'h24);
    hr(4'hC, v); chk("R3 wdata readback", v, 32'hDEAD_BEEF);
    stall = 2;
    push(1'b1, 32'h24, 32'hDEAD_BEEF);
    hw(4'h0, 32'h2);
    hr(4'h0, v); chk("R6 store pending view", v, 32'h2);
    chk("R4 request up", {31'b0, ib_req}, 32'h1);
    wait_ack(n);
    chk("R6 ack latency stall 2", 32'(n), 32'd3);
    hr(4'h0, v); chk("R6 store ack view", v, 32'h6);
    chk("R4 target written", mem[9], 32'hDEAD_BEEF);
    hr(4'h8, v); chk("R11 store keeps rdata", v, 32'h0);
    hw(4'h0, 32'h0);
    hr(4'h0, v); chk("R7 clear reads zero", v, 32'h0);
    chk("R7 no request after clear", {31'b0, ib_req}, 32'h0);

    // R5/R6: load with no stall
    stall = 0;
    hw(4'h4, 32'h10);
    push(1'b0, 32'h10, 32'h0);
    hw(4'h0, 32'h1);
    hr(4'h0, v); chk("R6 load pending view", v, 32'h1);
    wait_ack(n);
    chk("R6 ack latency stall 0", 32'(n), 32'd1);
    hr(4'h0, v); chk("R6 load ack view", v, 32'h5);
    hr(4'h8, v); chk("R5 load data", v, 32'hA500_0444);
    hw(4'h0, 32'h0);

    // R2/R3/R11: alignment and read-only register
    hw(4'h4, 32'h13);
    hr(4'h4, v); chk("R3 low addr bits dropped", v, 32'h10);
    hw(4'hD, 32'h77);
    hr(4'hC, v); chk("R2 misaligned write ignored", v, 32'hDEAD_BEEF);
    hr(4'h9, v); chk("R2 misaligned read zero", v, 32'h0);
    hw(4'h8, 32'h1234);
    hr(4'h8, v); chk("R11 rdata not writable", v, 32'hA500_0444);

    // R9: both bits set
    hw(4'h0, 32'h3);
    for (int i = 0; i < 3; i++) begin
      hr(4'h0, v); chk("R9 both bits cmd", v, 32'h0);
      chk("R9 both bits no request", {31'b0, ib_req}, 32'h0);
      @(negedge clk);
    end

    // R10: writes while busy are ignored
    stall = 8;
    push(1'b0, 32'h10, 32'h0);
    hw(4'h0, 32'h1);
    hw(4'h4, 32'h3C);
    hw(4'hC, 32'h1111_1111);
    hw(4'h0, 32'h2);
    wait_ack(n);
    hr(4'h4, v); chk("R10 addr frozen", v, 32'h10);
    hr(4'hC, v); chk("R10 wdata frozen", v, 32'hDEAD_BEEF);
    hr(4'h0, v); chk("R10 cmd write ignored busy", v, 32'h5);
    hw(4'h0, 32'h2);
    hr(4'h0, v); chk("R10 cmd write ignored in ack", v, 32'h5);
    hw(4'h0, 32'h0);

    // R8: clear while outstanding
    stall = 6;
    hw(4'h4, 32'h20);
    push(1'b0, 32'h20, 32'h0);
    hw(4'h0, 32'h1);
    hw(4'h0, 32'h0);
    hr(4'h0, v); chk("R8 cmd zero at once", v, 32'h0);
    chk("R8 request still held", {31'b0, ib_req}, 32'h1);
    hw(4'h0, 32'h1);
    hr(4'h0, v); chk("R8 cmd ignored while draining", v, 32'h0);
    for (int i = 0; i < 20; i++) begin
      if (!ib_req) break;
      @(negedge clk);
    end
    chk("R8 request dropped", {31'b0, ib_req}, 32'h0);
    repeat (3) @(negedge clk);
    hr(4'h0, v); chk("R8 no ack after abort", v, 32'h0);
    hr(4'h8, v); chk("R8 rdata kept", v, 32'hA500_0444);

    // R5: bridge usable after abort
    stall = 1;
    push(1'b0, 32'h20, 32'h0);
    hw(4'h0, 32'h1);
    wait_ack(n);
    chk("R6 ack latency stall 1", 32'(n), 32'd2);
    hr(4'h8, v); chk("R5 load after abort", v, 32'hA500_0888);
    hw(4'h0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule